// File: doc/BRIEF.md
# ADC Power-Up Sequencing Master

This block sits on the host side of a low-power serial converter. It drives the converter's control interface so that a burst of channel samples costs as little average power as possible. On each sample-period trigger it lowers chip select and wakes the converter. It then spends a programmable settling time in one of two ways.

In the first way it sends a wake byte that leaves the converter in fast power-down and then holds the serial clock low for a counted number of system clocks. In the second way it runs one dummy conversion, discards the result, and then emits a counted run of idle serial clocks with the data line at zero.

After settling, the block sends one control byte for each enabled channel, in ascending channel order. Every byte except the last keeps the converter powered. The last byte requests the power-down state that suits the chosen settling method. Each result is captured and presented together with its channel number and a one-cycle valid strobe.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset cs_no is 1, sclk_o and sdo_o are 0, res_valid_o is 0 and overrun_o is 0.
- R2: A trigger_i pulse while idle with a nonzero chan_en_i starts a burst. A trigger while idle with chan_en_i equal to 0 does nothing: cs_no stays 1 and overrun_o stays 0.
- R3: Every frame is 24 sclk_o pulses. The control byte goes out MSB first on sdo_o and is valid while sclk_o is high. Its bit 7 is 1 (start), bits 6:4 hold the channel in binary, and bits 3:2 are 11. Bits 1:0 hold the power code: 11 stays powered, 01 is fast power-down, 00 is full power-down.
- R4: With wait_mode_i=0, the first frame carries channel 0 with code 01, and no idle sclk pulses are emitted. The settling wait then holds sclk_o low for settle_i+1 cycles, so a burst of N conversions keeps cs_no low for 50*(N+1)+settle_i+1 cycles.
- R5: With wait_mode_i=1, the first frame is a dummy conversion with channel 0 and code 11. It is followed by exactly settle_i idle sclk pulses with sdo_o at 0 (none when settle_i=0), so cs_no stays low for 50*(N+1)+2*settle_i+2 cycles, or 50*(N+1) when settle_i=0. The result of the wake or dummy frame is never presented.
- R6: Exactly one conversion frame is sent for each set bit of chan_en_i, in ascending channel order.
- R7: Every conversion byte except the last carries code 11. The last one carries 00 when wait_mode_i=0 and 01 when wait_mode_i=1.
- R8: sdo_o is 0 at every sclk_o pulse except the first 8 pulses of a frame.
- R9: sdi_i is sampled at the end of the high phase of sclk pulses 10 to 19 of a conversion frame, MSB first, as a 10-bit result. The result appears on res_data_o with its channel on res_chan_o and res_valid_o high for one cycle, one cycle after the frame's last pulse.
- R10: A trigger while a burst is in progress is ignored and sets overrun_o on the next cycle. overrun_o stays 1 until ovr_clr_i is applied, and a trigger that counts as an overrun takes priority over a clear in the same cycle.
- R11: cs_no is low for the whole burst and high otherwise, sclk_o and sdo_o stay low while cs_no is high, and chan_en_i, wait_mode_i and settle_i are taken at the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trigger_i | input | 1 | Sample-period trigger pulse |
| wait_mode_i | input | 1 | 0: fast power-down wait, 1: dummy conversion plus idle clocks |
| settle_i | input | 16 | Settling length (system clocks or idle sclk pulses) |
| chan_en_i | input | 8 | Channel enable mask |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| sdi_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| sdo_o | output | 1 | Serial data to the converter |
| cs_no | output | 1 | Active-low chip select |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 10 | Captured conversion result |
| res_chan_o | output | 3 | Channel of the presented result |
| overrun_o | output | 1 | Sticky trigger-overrun flag |

## Verification
The bench sweeps every nonzero channel mask. The settling method follows the mask's parity, and several settle lengths are used, including zero. This separates errors in channel ordering, in marking the last byte, and in the power code of each method. A converter model in the bench decodes each control byte, returns values computed from the channel and the burst number, and counts idle pulses and stray ones on the data line. From these the bench tells apart a wrong settle count, a result taken from the dummy frame, and a misaligned capture window. Separate runs change the mask during a burst, trigger during a burst, and apply a clear together with an overlapping trigger, to tell apart state that is latched at the trigger from state that follows the live inputs.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_LAUNCH,
    S_RUN,
    S_WAIT
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_WAKE,
    PH_IDLE,
    PH_CONV
  } seq_phase_e;

  typedef enum logic [1:0] {
    PD_FULL = 2'b00,
    PD_FAST = 2'b01,
    PD_ON   = 2'b11
  } pd_code_e;

  // start | channel | unipolar single-ended | power code
  function automatic logic [7:0] make_ctrl(input logic [2:0] ch, input pd_code_e pd);
    return {1'b1, ch, 2'b11, pd};
  endfunction

endpackage

// File: rtl/adc_seq_shifter.sv
module adc_seq_shifter #(
  parameter int CNT_W     = 16,
  parameter int RES_W     = 10,
  parameter int CAP_FIRST = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [7:0]       byte_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             sdi_i,
  output logic             sclk_o,
  output logic             sdo_o,
  output logic             done_o,
  output logic [RES_W-1:0] res_o
);
  localparam int CAP_LAST = CAP_FIRST + RES_W - 1;

  logic             run_q, ph_q, done_q;
  logic [CNT_W-1:0] k_q, len_q;
  logic [7:0]       sh_q;
  logic [RES_W-1:0] res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      ph_q   <= 1'b0;
      done_q <= 1'b0;
      k_q    <= '0;
      len_q  <= '0;
      sh_q   <= '0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        run_q <= 1'b1;
        ph_q  <= 1'b0;
        k_q   <= '0;
        len_q <= len_i;
        sh_q  <= byte_i;
      end else if (run_q) begin
        if (!ph_q) begin
          ph_q <= 1'b1;
        end else begin
          ph_q <= 1'b0;
          sh_q <= {sh_q[6:0], 1'b0};
          if (k_q >= CNT_W'(CAP_FIRST) && k_q <= CNT_W'(CAP_LAST))
            res_q <= {res_q[RES_W-2:0], sdi_i};
          if (k_q == len_q - CNT_W'(1)) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            k_q <= k_q + CNT_W'(1);
          end
        end
      end
    end
  end

  assign sclk_o = run_q & ph_q;
  assign sdo_o  = run_q & sh_q[7];
  assign done_o = done_q;
  assign res_o  = res_q;

endmodule

// File: rtl/adc_seq_picker.sv
module adc_seq_picker #(
  parameter  int NUM_CH = 8,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] mask_i,
  input  logic [CH_W:0]     from_i,
  output logic [CH_W-1:0]   idx_o,
  output logic              last_o
);
  logic [CH_W-1:0] sel;
  logic            none_above;

  // lowest enabled channel at or above from_i
  always_comb begin
    sel = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask_i[i] && (CH_W+1)'(i) >= from_i) sel = CH_W'(i);
    end
  end

  always_comb begin
    none_above = 1'b1;
    for (int i = 0; i < NUM_CH; i++) begin
      if (mask_i[i] && CH_W'(i) > sel) none_above = 1'b0;
    end
  end

  assign idx_o  = sel;
  assign last_o = none_above;

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_seq_pkg::*;
#(
  parameter  int NUM_CH    = 8,
  parameter  int RES_W     = 10,
  parameter  int CNT_W     = 16,
  parameter  int FRAME_LEN = 24,
  parameter  int CAP_FIRST = 9,
  localparam int CH_W      = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trigger_i,
  input  logic              wait_mode_i,
  input  logic [CNT_W-1:0]  settle_i,
  input  logic [NUM_CH-1:0] chan_en_i,
  input  logic              ovr_clr_i,
  input  logic              sdi_i,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              cs_no,
  output logic              res_valid_o,
  output logic [RES_W-1:0]  res_data_o,
  output logic [CH_W-1:0]   res_chan_o,
  output logic              overrun_o
);

  seq_state_e        state_q;
  seq_phase_e        phase_q;
  logic [CH_W-1:0]   cur_q;
  logic              last_q;
  logic [NUM_CH-1:0] mask_q;
  logic              mode_q;
  logic [CNT_W-1:0]  settle_q;
  logic [7:0]        byte_q;
  logic [CNT_W-1:0]  len_q;

  logic              eng_done;
  logic [RES_W-1:0]  eng_res;
  logic              tmr_zero, tmr_load;
  logic [CH_W:0]     pick_from;
  logic [CH_W-1:0]   pick_idx;
  logic              pick_last;
  logic              conv_go, frame_end, busy;

  assign busy      = (state_q != S_IDLE);
  assign frame_end = (state_q == S_RUN) && eng_done;
  assign pick_from = (phase_q == PH_CONV) ? (CH_W+1)'(cur_q) + 1'b1 : '0;
  assign tmr_load  = frame_end && phase_q == PH_WAKE && !mode_q;

  always_comb begin
    conv_go = 1'b0;
    if (state_q == S_WAIT && tmr_zero) conv_go = 1'b1;
    if (frame_end) begin
      case (phase_q)
        PH_WAKE: conv_go = mode_q && settle_q == '0;
        PH_IDLE: conv_go = 1'b1;
        PH_CONV: conv_go = !last_q;
        default: conv_go = 1'b0;
      endcase
    end
  end

  adc_seq_shifter #(
    .CNT_W(CNT_W), .RES_W(RES_W), .CAP_FIRST(CAP_FIRST)
  ) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(state_q == S_LAUNCH),
    .byte_i (byte_q),
    .len_i  (len_q),
    .sdi_i  (sdi_i),
    .sclk_o (sclk_o),
    .sdo_o  (sdo_o),
    .done_o (eng_done),
    .res_o  (eng_res)
  );

  adc_seq_picker #(.NUM_CH(NUM_CH)) u_pick (
    .mask_i(mask_q),
    .from_i(pick_from),
    .idx_o (pick_idx),
    .last_o(pick_last)
  );

  adc_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .val_i (settle_q),
    .zero_o(tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      phase_q  <= PH_WAKE;
      cur_q    <= '0;
      last_q   <= 1'b0;
      mask_q   <= '0;
      mode_q   <= 1'b0;
      settle_q <= '0;
      byte_q   <= '0;
      len_q    <= '0;
    end else if (conv_go) begin
      cur_q   <= pick_idx;
      last_q  <= pick_last;
      byte_q  <= make_ctrl(pick_idx, pick_last ? (mode_q ? PD_FAST : PD_FULL) : PD_ON);
      len_q   <= CNT_W'(FRAME_LEN);
      phase_q <= PH_CONV;
      state_q <= S_LAUNCH;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (trigger_i && |chan_en_i) begin
            mask_q   <= chan_en_i;
            mode_q   <= wait_mode_i;
            settle_q <= settle_i;
            byte_q   <= make_ctrl(3'd0, wait_mode_i ? PD_ON : PD_FAST);
            len_q    <= CNT_W'(FRAME_LEN);
            phase_q  <= PH_WAKE;
            state_q  <= S_LAUNCH;
          end
        end
        S_LAUNCH: state_q <= S_RUN;
        S_RUN: begin
          if (eng_done) begin
            if (phase_q == PH_WAKE) begin
              if (!mode_q) begin
                state_q <= S_WAIT;
              end else begin
                // idle pulses reuse the shifter with an all-zero byte
                phase_q <= PH_IDLE;
                byte_q  <= '0;
                len_q   <= settle_q;
                state_q <= S_LAUNCH;
              end
            end else if (phase_q == PH_CONV) begin
              state_q <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_data_o  <= '0;
      res_chan_o  <= '0;
    end else begin
      res_valid_o <= frame_end && phase_q == PH_CONV;
      if (frame_end && phase_q == PH_CONV) begin
        res_data_o <= eng_res;
        res_chan_o <= cur_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                overrun_o <= 1'b0;
    else if (trigger_i && busy) overrun_o <= 1'b1;
    else if (ovr_clr_i)         overrun_o <= 1'b0;
  end

  assign cs_no = !busy;

endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic trigger_i,
  input logic ovr_clr_i,
  input logic sclk_o,
  input logic sdo_o,
  input logic cs_no,
  input logic res_valid_o,
  input logic overrun_o
);

  p_sclk_in_burst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no);

  p_sdo_in_burst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_o |-> !cs_no);

  p_valid_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  p_ovr_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trigger_i && !cs_no) |=> overrun_o);

  p_ovr_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !ovr_clr_i) |=> overrun_o);

  p_ovr_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_clr_i && !(trigger_i && !cs_no)) |=> !overrun_o);

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_no && !trigger_i) |=> cs_no);

endmodule

bind adc_pwr_seq adc_pwr_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .trigger_i  (trigger_i),
  .ovr_clr_i  (ovr_clr_i),
  .sclk_o     (sclk_o),
  .sdo_o      (sdo_o),
  .cs_no      (cs_no),
  .res_valid_o(res_valid_o),
  .overrun_o  (overrun_o)
);

// File: tb/adc_pwr_seq_test.sv
`timescale 1ns/1ps
module adc_pwr_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trigger = 1'b0;
  logic        wmode = 1'b0;
  logic [15:0] settle = '0;
  logic [7:0]  chan_en = '0;
  logic        ovr_clr = 1'b0;
  logic        sdi = 1'b0;
  logic        sclk, sdo, cs_n, rvalid, ovr;
  logic [9:0]  rdata;
  logic [2:0]  rchan;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  adc_pwr_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .trigger_i(trigger), .wait_mode_i(wmode),
    .settle_i(settle), .chan_en_i(chan_en), .ovr_clr_i(ovr_clr), .sdi_i(sdi),
    .sclk_o(sclk), .sdo_o(sdo), .cs_no(cs_n), .res_valid_o(rvalid),
    .res_data_o(rdata), .res_chan_o(rchan), .overrun_o(ovr)
  );

  // converter model and observation state
  int       burst_id = 0;
  int       mn = 0;
  logic [7:0] cb;
  logic [2:0] fch;
  logic [9:0] fv;
  int       bytes_seen [16];
  int       nbytes = 0;
  int       idle_p = 0;
  int       zviol = 0;
  int       cslow = 0;
  int       res_ch [16];
  int       res_dt [16];
  int       nres = 0;

  function automatic logic [9:0] conv_val(input int ch, input int b);
    return 10'((ch * 97 + b * 13 + 5) & 1023);
  endfunction

  always @(posedge sclk) begin
    if (mn == 0) begin
      if (sdo) begin
        mn = 1;
        cb = 8'h01;
      end else begin
        idle_p++;
      end
    end else begin
      mn++;
      if (mn <= 8) cb = {cb[6:0], sdo};
      else if (sdo) zviol++;
    end
    if (mn == 8) begin
      if (nbytes < 16) bytes_seen[nbytes] = int'(cb);
      nbytes++;
      fch = cb[6:4];
    end
    fv  = conv_val(int'(fch), burst_id);
    sdi = (mn >= 10 && mn <= 19) ? fv[19-mn] : 1'b0;
    if (mn == 24) mn = 0;
  end

  always @(negedge clk) begin
    if (!cs_n) cslow++;
    if (rvalid) begin
      if (nres < 16) begin
        res_ch[nres] = int'(rchan);
        res_dt[nres] = int'(rdata);
      end
      nres++;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic start_burst(input logic [7:0] m, input bit md, input int st);
    @(negedge clk);
    chan_en = m; wmode = md; settle = 16'(st);
    nbytes = 0; nres = 0; idle_p = 0; zviol = 0; cslow = 0;
    burst_id++;
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
  endtask

  task automatic finish_burst();
    while (!cs_n) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_burst(input logic [7:0] m, input bit md, input int st);
    int pop = 0;
    int k = 0;
    int exp_cs;
    int lastc = 0;
    for (int c = 0; c < 8; c++) if (m[c]) begin pop++; lastc = c; end
    chk(nres == pop, "R6 result count", nres, pop);
    chk(nbytes == pop + 1, "R3 frame count", nbytes, pop + 1);
    chk(bytes_seen[0] == (md ? 8'h8F : 8'h8D), md ? "R5 dummy byte" : "R4 wake byte",
        bytes_seen[0], md ? 8'h8F : 8'h8D);
    for (int c = 0; c < 8; c++) begin
      if (m[c] && k < 16 && k + 1 < 16) begin
        int pd = (c == lastc) ? (md ? 1 : 0) : 3;
        int eb = 128 + c * 16 + 12 + pd;
        chk(bytes_seen[k+1] == eb, "R7 conversion byte", bytes_seen[k+1], eb);
        chk(res_ch[k] == c, "R6 result channel", res_ch[k], c);
        chk(res_dt[k] == int'(conv_val(c, burst_id)), "R9 result data", res_dt[k],
            int'(conv_val(c, burst_id)));
        k++;
      end
    end
    chk(idle_p == (md ? st : 0), "R5 idle pulses", idle_p, md ? st : 0);
    exp_cs = 50 * (pop + 1) + (md ? ((st != 0) ? 2 * st + 2 : 0) : st + 1);
    chk(cslow == exp_cs, md ? "R5 burst length" : "R4 burst length", cslow, exp_cs);
    chk(zviol == 0, "R8 data line zero", zviol, 0);
    chk(mn == 0, "R3 frame alignment", mn, 0);
  endtask

  task automatic run_burst(input logic [7:0] m, input bit md, input int st);
    start_burst(m, md, st);
    finish_burst();
    check_burst(m, md, st);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1, "R1 cs_no", int'(cs_n), 1);
    chk(sclk == 1'b0 && sdo == 1'b0, "R1 sclk/sdo", int'({sclk, sdo}), 0);
    chk(rvalid == 1'b0, "R1 valid", int'(rvalid), 0);
    chk(ovr == 1'b0, "R1 overrun", int'(ovr), 0);

    // R2 empty mask trigger ignored
    chan_en = 8'h00; trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    begin
      int low = 0;
      for (int i = 0; i < 10; i++) begin
        if (!cs_n || sclk) low++;
        @(negedge clk);
      end
      chk(low == 0, "R2 empty mask", low, 0);
      chk(ovr == 1'b0, "R2 no overrun", int'(ovr), 0);
    end

    // near-exhaustive mask sweep
    for (int idx = 1; idx < 256; idx++) begin
      bit md = ^idx[7:0];
      int st = md ? (idx % 4) : (idx % 5);
      run_burst(8'(idx), md, st);
    end

    // longer settle in both methods
    run_burst(8'h81, 1'b0, 300);
    run_burst(8'h81, 1'b1, 40);

    // R10/R11: overlapping trigger, mask changed mid-burst
    start_burst(8'hFF, 1'b1, 2);
    repeat (30) @(negedge clk);
    chan_en = 8'h01; wmode = 1'b0; trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    chk(ovr == 1'b1, "R10 overrun set", int'(ovr), 1);
    finish_burst();
    check_burst(8'hFF, 1'b1, 2);
    begin
      int low = 0;
      for (int i = 0; i < 20; i++) begin
        if (!cs_n) low++;
        @(negedge clk);
      end
      chk(low == 0, "R10 overlapping trigger ignored", low, 0);
    end
    chk(ovr == 1'b1, "R10 overrun sticky", int'(ovr), 1);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    chk(ovr == 1'b0, "R10 overrun cleared", int'(ovr), 0);

    // R10 set wins over clear
    start_burst(8'h24, 1'b0, 3);
    repeat (20) @(negedge clk);
    trigger = 1'b1; ovr_clr = 1'b1;
    @(negedge clk);
    trigger = 1'b0; ovr_clr = 1'b0;
    chk(ovr == 1'b1, "R10 set beats clear", int'(ovr), 1);
    finish_burst();
    check_burst(8'h24, 1'b0, 3);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    chk(ovr == 1'b0, "R10 final clear", int'(ovr), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule